// File: doc/BRIEF.md
# Masked Argmax Unit

This unit picks the winning class out of a stream of signed class scores without ever recombining the shares of any score. Each score arrives as two Boolean shares whose XOR is the two's-complement value. The unit keeps a running maximum and a running winner index, both split into two shares. For every score after the first, a masked ripple-carry subtractor forms the sign of (running maximum − new score). That two-share sign bit then drives a pair of masked selectors, which swap in the new score and its index when the difference is negative.

The first score of a vector seeds the running maximum. A freshly masked encoding of index 0 seeds the winner. Later scores are taken one at a time through a valid/ready handshake. The input stalls until the update for the previous score has been committed. After the last score of a vector, the winning index leaves the unit as two shares, with a one-cycle done pulse. Fresh random bits come in on a dedicated input every cycle. The subtractor can be built purely combinational or with a register on its sign output.

Top module: `masked_argmax`

## Requirements
- R1: After reset, in_ready is 1, done is 0 and idx_sh0 XOR idx_sh1 equals 0.
- R2: The first score of a vector seeds the maximum. A vector of identical scores therefore yields index 0.
- R3: After the last of NUM_CLASSES scores, idx_sh0 XOR idx_sh1 equals the position (0 for the first score of the vector) of the largest signed score, where each score is score_sh0 XOR score_sh1 in two's complement.
- R4: A later score equal to the current maximum does not replace it, so among tied largest scores the earliest position wins.
- R5: Comparison is correct over the full signed range, including the most negative against the most positive score, without wraparound.
- R6: in_ready stays 1 after the first score of a vector is accepted. After any later score is accepted, in_ready is 0 for exactly 2 cycles (SUB_REG=0) or 3 cycles (SUB_REG=1).
- R7: done is a single-cycle pulse, which rises 3 cycles (SUB_REG=0: 2 cycles) after the edge that accepts the last score. idx_sh0 and idx_sh1 change only in a cycle where done is 1.
- R8: The combined result does not depend on how the scores are split into shares or on the values on rnd_in.
- R9: After done, the next accepted score starts a new vector at position 0, with no idle input required.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A score is present on the share inputs |
| in_ready | output | 1 | Unit accepts a score this cycle |
| score_sh0 | input | SCORE_W | Score share 0 |
| score_sh1 | input | SCORE_W | Score share 1 |
| rnd_in | input | RND_W | Fresh random bits (3*SCORE_W + 2*IDX_W) |
| done | output | 1 | One-cycle pulse: result shares updated |
| idx_sh0 | output | IDX_W | Winning index share 0 |
| idx_sh1 | output | IDX_W | Winning index share 1 |

## Verification
A corrupted share of the running maximum or a wrong carry in the masked subtractor shows at the ports only as a wrong recombined index, at the done pulse that closes the vector. The sweep therefore walks every arrangement of a small alphabet that holds the signed extremes, zero and minus one, so that each swap and each tie decision is visible in some vector. A sequencing fault appears earlier, as a wrong number of stall cycles on in_ready after the second score or as a done pulse in the wrong cycle. Repeating vectors with fresh share splits exposes any dependence of the result on mask values.

// File: rtl/masked_argmax_pkg.sv
package masked_argmax_pkg;

   typedef enum logic [1:0] {
      ST_TAKE   = 2'd0,
      ST_SIGN   = 2'd1,
      ST_SEL    = 2'd2,
      ST_COMMIT = 2'd3
   } amx_state_e;

   // Two-share AND with one fresh bit: bit 0 carries the masked product,
   // bit 1 carries the fresh bit, so their XOR is the plain product.
   function automatic logic [1:0] sec_and(input logic [1:0] x,
                                          input logic [1:0] y,
                                          input logic       r);
      logic z;
      z = r ^ (x[0] & y[0]);
      z = z ^ (x[0] & y[1]);
      z = z ^ (x[1] & y[0]);
      z = z ^ (x[1] & y[1]);
      return {r, z};
   endfunction

endpackage

// File: rtl/masked_sign_sub.sv
module masked_sign_sub
   import masked_argmax_pkg::*;
#(
   parameter int W       = 20,
   parameter int REG_OUT = 0,
   localparam int RW     = 2 * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [W-1:0]  a_sh0,
   input  logic [W-1:0]  a_sh1,
   input  logic [W-1:0]  b_sh0,
   input  logic [W-1:0]  b_sh1,
   input  logic [RW-1:0] rnd,
   output logic [1:0]    sgn
);

   logic [1:0] sgn_raw;
   logic [1:0] sgn_q;

   // a + ~b + 1, computed on shares; only the sign of the W+1 bit result
   // is produced (operands sign-extended by one bit, so no wraparound).
   always_comb begin : p_chain
      logic [1:0] c;
      logic [1:0] x;
      logic [1:0] y;
      logic [1:0] g;
      logic [1:0] p;
      logic [1:0] t;
      c = 2'b01;
      for (int i = 0; i < W; i++) begin
         x = {a_sh1[i], a_sh0[i]};
         y = {b_sh1[i], ~b_sh0[i]};
         g = sec_and(x, y, rnd[2*i]);
         p = x ^ y;
         t = sec_and(c, p, rnd[2*i+1]);
         c = g ^ t;
      end
      sgn_raw = {a_sh1[W-1] ^ b_sh1[W-1] ^ c[1],
                 a_sh0[W-1] ^ ~b_sh0[W-1] ^ c[0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sgn_q <= '0;
      else if (en)  sgn_q <= sgn_raw;
   end

   generate
      if (REG_OUT != 0) begin : g_reg
         assign sgn = sgn_q;
      end else begin : g_comb
         assign sgn = sgn_raw;
      end
   endgenerate

endmodule

// File: rtl/masked_sel.sv
module masked_sel #(
   parameter int N = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [1:0]   sel,
   input  logic [N-1:0] old_sh0,
   input  logic [N-1:0] old_sh1,
   input  logic [N-1:0] new_sh0,
   input  logic [N-1:0] new_sh1,
   input  logic [N-1:0] rnd,
   output logic [N-1:0] flip_sh0,
   output logic [N-1:0] flip_sh1
);

   // Shares of sel & (old ^ new); the caller XORs them into old.
   // Cross products are registered before they are combined.
   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_bit
         logic d0, d1;
         logic t0, t1, t2, t3, tr;
         assign d0 = old_sh0[gi] ^ new_sh0[gi];
         assign d1 = old_sh1[gi] ^ new_sh1[gi];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               t0 <= 1'b0; t1 <= 1'b0; t2 <= 1'b0; t3 <= 1'b0; tr <= 1'b0;
            end else if (en) begin
               t0 <= rnd[gi] ^ (sel[0] & d0);
               t1 <= sel[0] & d1;
               t2 <= sel[1] & d0;
               t3 <= sel[1] & d1;
               tr <= rnd[gi];
            end
         end
         assign flip_sh0[gi] = ((t0 ^ t1) ^ t2) ^ t3;
         assign flip_sh1[gi] = tr;
      end
   endgenerate

endmodule

// File: rtl/masked_argmax.sv
module masked_argmax
   import masked_argmax_pkg::*;
#(
   parameter int SCORE_W     = 20,
   parameter int NUM_CLASSES = 10,
   parameter int SUB_REG     = 0,
   parameter int IDX_W       = $clog2(NUM_CLASSES),
   parameter int RND_W       = 3 * SCORE_W + 2 * IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [SCORE_W-1:0] score_sh0,
   input  logic [SCORE_W-1:0] score_sh1,
   input  logic [RND_W-1:0]   rnd_in,
   output logic               done,
   output logic [IDX_W-1:0]   idx_sh0,
   output logic [IDX_W-1:0]   idx_sh1
);

   localparam int SUB_RW  = 2 * SCORE_W;
   localparam int SEL_LO  = SUB_RW;
   localparam int IXR_LO  = SUB_RW + SCORE_W;
   localparam int MSK_LO  = IXR_LO + IDX_W;
   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(NUM_CLASSES - 1);

   generate
      if (SCORE_W < 2) begin : g_bad_w
         $error("masked_argmax: SCORE_W must be at least 2");
      end
      if (NUM_CLASSES < 2) begin : g_bad_n
         $error("masked_argmax: NUM_CLASSES must be at least 2");
      end
      if ((1 << IDX_W) < NUM_CLASSES) begin : g_bad_ix
         $error("masked_argmax: IDX_W too narrow for NUM_CLASSES");
      end
      if (SUB_REG < 0 || SUB_REG > 1) begin : g_bad_sub
         $error("masked_argmax: SUB_REG must be 0 or 1");
      end
      if (RND_W != 3 * SCORE_W + 2 * IDX_W) begin : g_bad_rw
         $error("masked_argmax: RND_W must equal 3*SCORE_W+2*IDX_W");
      end
   endgenerate

   amx_state_e         state;
   logic [IDX_W-1:0]   pos;
   logic [SCORE_W-1:0] max_sh0, max_sh1;
   logic [SCORE_W-1:0] cand_sh0, cand_sh1;
   logic [IDX_W-1:0]   win_sh0, win_sh1;
   logic [IDX_W-1:0]   cix_sh0, cix_sh1;
   logic [IDX_W-1:0]   out_sh0, out_sh1;
   logic               done_q;

   logic               take;
   logic [1:0]         sgn;
   logic [SCORE_W-1:0] fmax_sh0, fmax_sh1;
   logic [IDX_W-1:0]   fidx_sh0, fidx_sh1;
   logic [IDX_W-1:0]   imask;
   logic               sel_en;
   logic               sub_en;

   assign in_ready = (state == ST_TAKE);
   assign take     = in_valid && in_ready;
   assign imask    = rnd_in[MSK_LO +: IDX_W];
   assign sel_en   = (state == ST_SEL);
   assign sub_en   = (state == ST_SIGN);

   masked_sign_sub #(
      .W       (SCORE_W),
      .REG_OUT (SUB_REG)
   ) u_sub (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sub_en),
      .a_sh0 (max_sh0),
      .a_sh1 (max_sh1),
      .b_sh0 (cand_sh0),
      .b_sh1 (cand_sh1),
      .rnd   (rnd_in[SUB_RW-1:0]),
      .sgn   (sgn)
   );

   masked_sel #(.N(SCORE_W)) u_sel_max (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sel_en),
      .sel      (sgn),
      .old_sh0  (max_sh0),
      .old_sh1  (max_sh1),
      .new_sh0  (cand_sh0),
      .new_sh1  (cand_sh1),
      .rnd      (rnd_in[SEL_LO +: SCORE_W]),
      .flip_sh0 (fmax_sh0),
      .flip_sh1 (fmax_sh1)
   );

   masked_sel #(.N(IDX_W)) u_sel_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sel_en),
      .sel      (sgn),
      .old_sh0  (win_sh0),
      .old_sh1  (win_sh1),
      .new_sh0  (cix_sh0),
      .new_sh1  (cix_sh1),
      .rnd      (rnd_in[IXR_LO +: IDX_W]),
      .flip_sh0 (fidx_sh0),
      .flip_sh1 (fidx_sh1)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_TAKE;
         pos      <= '0;
         max_sh0  <= '0;
         max_sh1  <= '0;
         cand_sh0 <= '0;
         cand_sh1 <= '0;
         win_sh0  <= '0;
         win_sh1  <= '0;
         cix_sh0  <= '0;
         cix_sh1  <= '0;
         out_sh0  <= '0;
         out_sh1  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_TAKE: begin
               if (take) begin
                  if (pos == '0) begin
                     max_sh0 <= score_sh0;
                     max_sh1 <= score_sh1;
                     win_sh0 <= imask;
                     win_sh1 <= imask;
                     pos     <= IDX_W'(1);
                  end else begin
                     cand_sh0 <= score_sh0;
                     cand_sh1 <= score_sh1;
                     cix_sh0  <= pos ^ imask;
                     cix_sh1  <= imask;
                     state    <= (SUB_REG != 0) ? ST_SIGN : ST_SEL;
                  end
               end
            end
            ST_SIGN: state <= ST_SEL;
            ST_SEL:  state <= ST_COMMIT;
            ST_COMMIT: begin
               max_sh0 <= max_sh0 ^ fmax_sh0;
               max_sh1 <= max_sh1 ^ fmax_sh1;
               win_sh0 <= win_sh0 ^ fidx_sh0;
               win_sh1 <= win_sh1 ^ fidx_sh1;
               if (pos == LAST_POS) begin
                  out_sh0 <= win_sh0 ^ fidx_sh0;
                  out_sh1 <= win_sh1 ^ fidx_sh1;
                  done_q  <= 1'b1;
                  pos     <= '0;
               end else begin
                  pos <= pos + IDX_W'(1);
               end
               state <= ST_TAKE;
            end
            default: state <= ST_TAKE;
         endcase
      end
   end

   assign done    = done_q;
   assign idx_sh0 = out_sh0;
   assign idx_sh1 = out_sh1;

endmodule

// File: rtl/masked_argmax_chk.sv
module masked_argmax_chk #(
   parameter int IDX_W       = 4,
   parameter int NUM_CLASSES = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             done,
   input logic [IDX_W-1:0] idx_sh0,
   input logic [IDX_W-1:0] idx_sh1
);

   // R7: result pulse lasts one cycle
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: result shares move only together with done
   assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(idx_sh0) && $stable(idx_sh1)));

   // R3: recombined winner is a legal class position
   assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(idx_sh0 ^ idx_sh1) < NUM_CLASSES));

   // R6 / R9: the unit is ready again as soon as a vector closes
   assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> in_ready);

   // R6: a stalled input cannot be accepted twice in a row
   assert_no_accept_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && $past(in_ready) && $past(in_valid)) |=> (!in_ready || done));

endmodule

bind masked_argmax masked_argmax_chk #(
   .IDX_W       (IDX_W),
   .NUM_CLASSES (NUM_CLASSES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .done     (done),
   .idx_sh0  (idx_sh0),
   .idx_sh1  (idx_sh1)
);

// File: tb/masked_argmax_bench.sv
module masked_argmax_bench;

   localparam int W  = 6;
   localparam int N  = 4;
   localparam int IW = 2;
   localparam int RW = 3 * W + 2 * IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [W-1:0]  score_sh0 = '0;
   logic [W-1:0]  score_sh1 = '0;
   logic [RW-1:0] rnd_in = '0;
   logic          done;
   logic [IW-1:0] idx_sh0, idx_sh1;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   always @(negedge clk) rnd_in = RW'({$urandom(), $urandom()});

   masked_argmax #(
      .SCORE_W     (W),
      .NUM_CLASSES (N),
      .SUB_REG     (1)
   ) u_masked_argmax (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .score_sh0 (score_sh0),
      .score_sh1 (score_sh1),
      .rnd_in    (rnd_in),
      .done      (done),
      .idx_sh0   (idx_sh0),
      .idx_sh1   (idx_sh1)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Sends one vector and checks handshake, done timing and winner.
   task automatic run_vec(input int v0, input int v1, input int v2, input int v3,
                          input string req);
      int vals [N];
      int expi;
      vals[0] = v0; vals[1] = v1; vals[2] = v2; vals[3] = v3;
      expi = 0;
      for (int k = 1; k < N; k++) if (vals[k] > vals[expi]) expi = k;
      for (int k = 0; k < N; k++) begin
         while (!in_ready) @(negedge clk);
         in_valid  = 1'b1;
         score_sh1 = W'($urandom());
         score_sh0 = W'(vals[k]) ^ score_sh1;
         @(negedge clk);
         in_valid = 1'b0;
         if (k == 0) check(in_ready == 1'b1, "R6 first", int'(in_ready), 1);
         if (k == 1) begin
            int lo = 0;
            while (!in_ready && lo < 20) begin
               lo++;
               @(negedge clk);
            end
            check(lo == 3, "R6 stall", lo, 3);
         end
         if (k == N - 1) begin
            check(done == 1'b0, "R7 early", int'(done), 0);
            for (int d = 0; d < 2; d++) begin
               @(negedge clk);
               check(done == 1'b0, "R7 early", int'(done), 0);
            end
            @(negedge clk);
            check(done == 1'b1, "R7 pulse", int'(done), 1);
            check(int'(idx_sh0 ^ idx_sh1) == expi, req, int'(idx_sh0 ^ idx_sh1), expi);
            @(negedge clk);
            check(done == 1'b0, "R7 width", int'(done), 0);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int alpha [4];
      alpha[0] = -32; alpha[1] = -1; alpha[2] = 0; alpha[3] = 31;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
      check(done == 1'b0, "R1 done", int'(done), 0);
      check(int'(idx_sh0 ^ idx_sh1) == 0, "R1 idx", int'(idx_sh0 ^ idx_sh1), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_vec(5, 5, 5, 5, "R2 all equal");
      run_vec(-3, 7, 7, 2, "R4 tie");
      run_vec(-32, 31, -32, 0, "R5 extremes");
      run_vec(31, -32, -32, -32, "R5 first max");
      run_vec(-5, -4, -3, -2, "R3 rising");
      run_vec(1, 2, 3, 4, "R9 back-to-back");

      // Exhaustive sweep over a 4-value alphabet in all positions (R3, R4, R5)
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int d = 0; d < 4; d++)
                  run_vec(alpha[a], alpha[b], alpha[c], alpha[d], "R3 sweep");

      // Random vectors, each repeated with fresh shares and randomness (R8)
      for (int r = 0; r < 150; r++) begin
         int s0, s1, s2, s3;
         s0 = int'($urandom_range(63)) - 32;
         s1 = int'($urandom_range(63)) - 32;
         s2 = int'($urandom_range(63)) - 32;
         s3 = int'($urandom_range(63)) - 32;
         run_vec(s0, s1, s2, s3, "R3 random");
         run_vec(s0, s1, s2, s3, "R8 remasked");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule